// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is the datapath core of a small accumulator-style processor. Two operand words and an input carry enter a single combinational network. That network forms an arithmetic result, a bitwise logic result and a one-place shift of the first operand. A two-bit group select picks one of the three results, and a two-bit operation select chooses the operation inside that group. The arithmetic group is one ripple adder computing A + Y + carry-in. Its Y operand comes from a four-way selector: B, the complement of B, all zeros or all ones. With the two carry-in values, this gives eight arithmetic results.

The selected result and its carry-out go into a destination register. The register loads only when the load enable is high, so the surrounding control can keep a value across cycles. The word width is a parameter. A parameter also allows the output register to be removed, which makes the block purely combinational.

Top module: `als_unit`

## Requirements
- R1: When grp_sel is 00, {cout_q, res_q} becomes A + Y + cin modulo 2^(W+1). Y is selected by op_sel: 00 gives B, 01 gives ~B, 10 gives all zeros, 11 gives all ones.
- R2: With grp_sel arithmetic, op_sel 01 and cin 1, res_q is A − B modulo 2^W and cout_q is 1 exactly when A ≥ B unsigned. With cin 0, res_q is A − B − 1.
- R3: With grp_sel arithmetic, the remaining settings behave as follows. op_sel 10 with cin 1 increments A. op_sel 11 with cin 0 decrements A, and cout_q is 0 only when A is zero. op_sel 10 with cin 0 passes A with cout_q 0. op_sel 11 with cin 1 passes A with cout_q 1.
- R4: When grp_sel is 10, op_sel selects the logic result: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, 11 gives NOT A.
- R5: When grp_sel is 11, op_sel[0] = 0 shifts A right by one with a zero entering the MSB. op_sel[0] = 1 shifts A left by one with a zero entering the LSB. op_sel[1] has no effect.
- R6: cout_q is 0 after any load made with grp_sel 10 or 11.
- R7: The result of the inputs present at a rising clock edge with ld_en = 1 appears on res_q/cout_q right after that edge.
- R8: At an edge with ld_en = 0, res_q and cout_q keep their values whatever the operand and select inputs are.
- R9: rst_n low clears res_q and cout_q to zero at once, without waiting for a clock edge.
- R10: grp_sel 01 gives exactly the same arithmetic results as grp_sel 00, for every op_sel and cin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load enable of the destination register |
| opa | input | W | Operand A |
| opb | input | W | Operand B |
| cin | input | 1 | Input carry of the adder |
| grp_sel | input | 2 | Group select: 00/01 arithmetic, 10 logic, 11 shift |
| op_sel | input | 2 | Operation select within the group |
| res_q | output | W | Registered result word |
| cout_q | output | 1 | Registered carry-out |

## Verification
Every internal fault in this block appears at the ports one clock edge after the load that used it, because nothing is kept across loads except the destination register. A broken carry link shows up as a wrong high bit and carry-out when operands ripple fully, such as all ones plus one. A swapped Y selection shows up under the subtract, increment and decrement codes. A misrouted group or shift direction corrupts the corner operands zero, all ones and sign-bit-only. A faulty load gate shows up as output drift during cycles with the enable low.

// File: rtl/als_pkg.sv
package als_pkg;

  typedef enum logic [1:0] {
    GRP_ARITH_A = 2'b00,
    GRP_ARITH_B = 2'b01,
    GRP_LOGIC   = 2'b10,
    GRP_SHIFT   = 2'b11
  } als_grp_e;

  typedef enum logic [1:0] {
    YSEL_B    = 2'b00,
    YSEL_NOTB = 2'b01,
    YSEL_ZERO = 2'b10,
    YSEL_ONES = 2'b11
  } als_ysel_e;

  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_NOTA = 2'b11
  } als_lop_e;

  function automatic logic grp_is_arith(input logic [1:0] grp);
    return (grp[1] == 1'b0);
  endfunction

endpackage

// File: rtl/als_y_select.sv
module als_y_select #(
  parameter int W = 8
) (
  input  logic [W-1:0] b_in,
  input  logic [1:0]   sel,
  output logic [W-1:0] y_out
);
  import als_pkg::*;

  always_comb begin
    unique case (als_ysel_e'(sel))
      YSEL_B:    y_out = b_in;
      YSEL_NOTB: y_out = ~b_in;
      YSEL_ZERO: y_out = '0;
      YSEL_ONES: y_out = '1;
      default:   y_out = b_in;
    endcase
  end

endmodule

// File: rtl/als_ripple_adder.sv
module als_ripple_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_out
);
  logic [W:0] chain;

  assign chain[0] = c_in;

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic prop;
    logic gen;
    assign prop         = x_in[i] ^ y_in[i];
    assign gen          = x_in[i] & y_in[i];
    assign sum[i]       = prop ^ chain[i];
    assign chain[i + 1] = gen | (prop & chain[i]);
  end

  assign c_out = chain[W];

endmodule

// File: rtl/als_logic_unit.sv
module als_logic_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [1:0]   sel,
  output logic [W-1:0] f_out
);
  import als_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [3:0] cand;
    assign cand[LOP_AND]  = a_in[i] & b_in[i];
    assign cand[LOP_OR]   = a_in[i] | b_in[i];
    assign cand[LOP_XOR]  = a_in[i] ^ b_in[i];
    assign cand[LOP_NOTA] = ~a_in[i];
    assign f_out[i]       = cand[sel];
  end

endmodule

// File: rtl/als_shifter.sv
module als_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic         go_left,
  output logic [W-1:0] s_out
);
  logic [W-1:0] to_right;
  logic [W-1:0] to_left;

  assign to_right = {1'b0, a_in[W-1:1]};
  assign to_left  = {a_in[W-2:0], 1'b0};
  assign s_out    = go_left ? to_left : to_right;

endmodule

// File: rtl/als_unit.sv
module als_unit #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  input  logic [1:0]   grp_sel,
  input  logic [1:0]   op_sel,
  output logic [W-1:0] res_q,
  output logic         cout_q
);
  import als_pkg::*;

  logic [W-1:0] y_opnd;
  logic [W-1:0] arith_res;
  logic         arith_cout;
  logic [W-1:0] logic_res;
  logic [W-1:0] shift_res;
  logic [W-1:0] res_d;
  logic         cout_d;

  als_y_select #(.W(W)) u_ysel (
    .b_in  (opb),
    .sel   (op_sel),
    .y_out (y_opnd)
  );

  als_ripple_adder #(.W(W)) u_add (
    .x_in  (opa),
    .y_in  (y_opnd),
    .c_in  (cin),
    .sum   (arith_res),
    .c_out (arith_cout)
  );

  als_logic_unit #(.W(W)) u_lgc (
    .a_in  (opa),
    .b_in  (opb),
    .sel   (op_sel),
    .f_out (logic_res)
  );

  als_shifter #(.W(W)) u_shf (
    .a_in    (opa),
    .go_left (op_sel[0]),
    .s_out   (shift_res)
  );

  // group multiplexer: next value of the destination register
  always_comb begin
    res_d  = arith_res;
    cout_d = 1'b0;
    unique case (als_grp_e'(grp_sel))
      GRP_ARITH_A, GRP_ARITH_B: begin
        res_d  = arith_res;
        cout_d = arith_cout;
      end
      GRP_LOGIC: res_d = logic_res;
      GRP_SHIFT: res_d = shift_res;
      default:   res_d = arith_res;
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q  <= '0;
        cout_q <= 1'b0;
      end else if (ld_en) begin
        res_q  <= res_d;
        cout_q <= cout_d;
      end
    end
  end else begin : g_comb
    assign res_q  = res_d;
    assign cout_q = cout_d;
  end

endmodule

// File: rtl/als_unit_chk.sv
module als_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ld_en,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         cin,
  input logic [1:0]   grp_sel,
  input logic [1:0]   op_sel,
  input logic [W-1:0] res_q,
  input logic         cout_q
);

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> ($stable(res_q) && $stable(cout_q))); // R8

  AST_NO_CARRY_NONARITH: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && grp_sel[1]) |=> !cout_q); // R6

  AST_SHL_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && grp_sel == 2'b11 && op_sel[0]) |=> (res_q[0] == 1'b0)); // R5

  AST_SHR_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && grp_sel == 2'b11 && !op_sel[0]) |=> (res_q[W-1] == 1'b0)); // R5

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !grp_sel[1] && op_sel == 2'b00) |=>
      ({cout_q, res_q} == ({1'b0, $past(opa)} + {1'b0, $past(opb)} + {{W{1'b0}}, $past(cin)}))); // R1

  AST_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !grp_sel[1] && op_sel == 2'b10 && !cin) |=>
      (res_q == $past(opa) && !cout_q)); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (res_q == '0 && !cout_q)); // R9

endmodule

bind als_unit als_unit_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ld_en   (ld_en),
  .opa     (opa),
  .opb     (opb),
  .cin     (cin),
  .grp_sel (grp_sel),
  .op_sel  (op_sel),
  .res_q   (res_q),
  .cout_q  (cout_q)
);

// File: tb/test_als_unit.sv
module test_als_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam logic [W-1:0] SIGN = {1'b1, {(W-1){1'b0}}};

  logic         clk;
  logic         rst_n;
  logic         ld_en;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic         cin;
  logic [1:0]   grp_sel;
  logic [1:0]   op_sel;
  logic [W-1:0] res_q;
  logic         cout_q;

  int n_vec;
  int n_bad;

  als_unit #(.W(W)) i_als_unit (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .opa(opa), .opb(opb),
    .cin(cin), .grp_sel(grp_sel), .op_sel(op_sel), .res_q(res_q), .cout_q(cout_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // model built from the requirement text
  function automatic logic [W:0] model(input logic [1:0] g, input logic [1:0] o,
                                       input logic c, input logic [W-1:0] a,
                                       input logic [W-1:0] b);
    logic [W-1:0] y;
    if (g[1] == 1'b0) begin
      case (o)
        2'b00: y = b;
        2'b01: y = ~b;
        2'b10: y = '0;
        default: y = '1;
      endcase
      return {1'b0, a} + {1'b0, y} + {{W{1'b0}}, c};
    end else if (g == 2'b10) begin
      case (o)
        2'b00: return {1'b0, a & b};
        2'b01: return {1'b0, a | b};
        2'b10: return {1'b0, a ^ b};
        default: return {1'b0, ~a};
      endcase
    end else begin
      if (o[0]) return {1'b0, a << 1};
      return {1'b0, a >> 1};
    end
  endfunction

  task automatic check(input string req, input logic [W-1:0] er, input logic ec);
    n_vec++;
    if (res_q !== er || cout_q !== ec) begin
      n_bad++;
      $display("FAIL %s res=%h exp=%h cout=%b exp=%b", req, res_q, er, cout_q, ec);
    end
  endtask

  task automatic apply(input logic [1:0] g, input logic [1:0] o, input logic c,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    grp_sel = g; op_sel = o; cin = c; opa = a; opb = b; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_code(input string req, input logic [1:0] g, input logic [1:0] o,
                          input logic c);
    logic [W-1:0] corner [3];
    logic [W:0] e;
    corner[0] = '0; corner[1] = '1; corner[2] = SIGN;
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++) begin
        apply(g, o, c, corner[i], corner[j]);
        e = model(g, o, c, corner[i], corner[j]);
        check(req, e[W-1:0], e[W]);
      end
    end
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      ra = W'($urandom);
      rb = W'($urandom);
      apply(g, o, c, ra, rb);
      e = model(g, o, c, ra, rb);
      check(req, e[W-1:0], e[W]);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ld_en = 1'b0; opa = '0; opb = '0; cin = 1'b0;
    grp_sel = 2'b00; op_sel = 2'b00;
    repeat (3) @(negedge clk);
    check("R9 reset", '0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_add_sub();
    for (int c = 0; c < 2; c++) begin
      run_code("R1 add", 2'b00, 2'b00, c[0]);
      run_code("R2 sub", 2'b00, 2'b01, c[0]);
    end
    apply(2'b00, 2'b01, 1'b1, 8'h05, 8'h07);
    check("R2 borrow", 8'hFE, 1'b0);
    apply(2'b00, 2'b01, 1'b1, 8'h07, 8'h07);
    check("R2 equal", 8'h00, 1'b1);
    apply(2'b00, 2'b00, 1'b1, 8'hFF, 8'h00);
    check("R1 full ripple", 8'h00, 1'b1);
  endtask

  task automatic t_inc_dec();
    for (int c = 0; c < 2; c++) begin
      run_code("R3 zero-y", 2'b00, 2'b10, c[0]);
      run_code("R3 ones-y", 2'b00, 2'b11, c[0]);
    end
    apply(2'b00, 2'b11, 1'b0, 8'h00, 8'h3C);
    check("R3 decrement zero", 8'hFF, 1'b0);
    apply(2'b00, 2'b11, 1'b1, 8'h5A, 8'h00);
    check("R3 pass with carry", 8'h5A, 1'b1);
  endtask

  task automatic t_logic();
    for (int o = 0; o < 4; o++) run_code("R4 logic", 2'b10, o[1:0], o[0]);
    apply(2'b10, 2'b11, 1'b1, 8'hF0, 8'hAA);
    check("R6 logic carry", 8'h0F, 1'b0);
  endtask

  task automatic t_shift();
    for (int o = 0; o < 4; o++) run_code("R5 shift", 2'b11, o[1:0], 1'b1);
    apply(2'b11, 2'b10, 1'b1, 8'h81, 8'hFF);
    check("R5 op1 ignored", 8'h40, 1'b0);
    apply(2'b11, 2'b01, 1'b1, 8'hFF, 8'h00);
    check("R6 shift carry", 8'hFE, 1'b0);
  endtask

  task automatic t_alias();
    for (int o = 0; o < 4; o++) begin
      run_code("R10 alias", 2'b01, o[1:0], 1'b0);
      run_code("R10 alias", 2'b01, o[1:0], 1'b1);
    end
  endtask

  task automatic t_hold();
    apply(2'b00, 2'b00, 1'b1, 8'h12, 8'hF0);
    check("R7 load", 8'h03, 1'b1);
    @(negedge clk);
    grp_sel = 2'b10; op_sel = 2'b11; opa = 8'h00; opb = 8'h55; cin = 1'b0; ld_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 hold", 8'h03, 1'b1);
  endtask

  task automatic t_async_reset();
    apply(2'b10, 2'b11, 1'b0, 8'h00, 8'h00);
    check("R7 load", 8'hFF, 1'b0);
    #1 rst_n = 1'b0;
    #1 check("R9 async clear", '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R7 watchdog expired");
    finish_run();
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    t_reset();
    t_add_sub();
    t_inc_dec();
    t_logic();
    t_shift();
    t_alias();
    t_hold();
    t_async_reset();
    finish_run();
  end

endmodule